// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block expands a single column address into the complete list of column addresses for one DRAM read or write burst. When a start pulse arrives, it captures the column address from the command and a four-bit mode word. Bits 2:0 of the mode word give the burst length and bit 3 gives the ordering. From the next clock on, the block presents one column address per cycle for each beat of the burst. The first and last beats are marked.

The beats stay inside a naturally aligned block whose size equals the burst length. The low column bits, as many as log2 of the length, are the starting offset inside that block. The column bits above them are copied unchanged from the starting column. The offset then runs in one of two orders, chosen per burst. Sequential order counts upward and wraps back to the start of the block. Interleaved order flips offset bits by XOR with the beat number. Reads and writes use the same programmed length, so the block needs no direction input.

A controller pulses the start input when it issues a column command. It then takes one address per cycle while the valid strobe is high. A start pulse that arrives with a reserved length code produces an error pulse and no burst.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, col_vld_o, first_o, last_o, busy_o and err_o are all low, and they stay low until a start pulse is accepted.
- R2: A start pulse taken while idle with length code 3'b001, 3'b010 or 3'b011 (mode_i[2:0]) produces 2, 4 or 8 beats respectively. There is one beat per cycle with col_vld_o high, and beat 0 appears in the cycle after the clock edge that sampled the start pulse.
- R3: With mode_i[3] = 0 (sequential), beat k carries the block offset (s + k) modulo L. Here s is the starting column's low log2(L) bits and L is the burst length.
- R4: With mode_i[3] = 1 (interleaved), beat k carries the block offset s XOR k.
- R5: Every column bit at position log2(L) and above equals the starting column for the whole burst, so a burst wraps inside its aligned block and never enters the next one.
- R6: first_o is high on beat 0 only, last_o is high on the final beat only, and both are high only while col_vld_o is high.
- R7: busy_o is high exactly during the cycles that present beats. A start pulse sampled while busy_o is high is ignored, and the running burst continues unchanged. A start sampled in the first cycle after the last beat is accepted.
- R8: A start pulse taken while idle with any other length code raises err_o for exactly one cycle, in the cycle after the sampling edge, and produces no beats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for a new burst |
| start_col_i | input | COL_W | Starting column address from the command |
| mode_i | input | 4 | Mode word: [2:0] length code, [3] ordering (1 = interleaved) |
| col_o | output | COL_W | Column address of the current beat |
| col_vld_o | output | 1 | col_o holds a beat address |
| first_o | output | 1 | Current beat is the first of the burst |
| last_o | output | 1 | Current beat is the last of the burst |
| busy_o | output | 1 | A burst is in progress |
| err_o | output | 1 | One-cycle pulse for a start with a reserved length code |

## Verification
Some properties are checked on every cycle. The bits above the block offset hold steady from beat to beat, first and last never coincide, and a burst always follows an accepted start. The beat counter never leaves the programmed length, the busy phase ends right after the last beat, no load occurs while a burst runs, and the error pulse never overlaps a burst. The exact offset for each beat under both orderings only shows in the bench scenarios. So do the beat count for each length code, the rejection of a start pulse in the middle of a burst, and the absence of any beat after a reserved code. The bench compares these against its own model of the address order.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  localparam int OFS_W = 3;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } burst_order_e;

  typedef logic [1:0] len_log2_t;

  localparam logic [2:0] CODE_LEN2 = 3'b001;
  localparam logic [2:0] CODE_LEN4 = 3'b010;
  localparam logic [2:0] CODE_LEN8 = 3'b011;

  function automatic logic code_is_legal(input logic [2:0] code);
    return (code == CODE_LEN2) || (code == CODE_LEN4) || (code == CODE_LEN8);
  endfunction

  function automatic len_log2_t code_to_log2(input logic [2:0] code);
    len_log2_t r;
    case (code)
      CODE_LEN2: r = 2'd1;
      CODE_LEN4: r = 2'd2;
      CODE_LEN8: r = 2'd3;
      default:   r = 2'd0;
    endcase
    return r;
  endfunction

  function automatic logic [OFS_W-1:0] len_mask(input len_log2_t l);
    logic [3:0] full;
    full = (4'd1 << l) - 4'd1;
    return full[OFS_W-1:0];
  endfunction

  function automatic logic [OFS_W-1:0] beat_offset(
    input logic [OFS_W-1:0] start_ofs,
    input logic [OFS_W-1:0] beat,
    input burst_order_e     ord,
    input len_log2_t        l
  );
    logic [OFS_W-1:0] m;
    m = len_mask(l);
    if (ord == ORD_ILV) return (start_ofs ^ beat) & m;
    else                return (start_ofs + beat) & m;
  endfunction

endpackage

// File: rtl/burst_mode_dec.sv
module burst_mode_dec
  import burst_col_pkg::*;
(
  input  logic [3:0]   mode_i,
  output len_log2_t    len_log2_o,
  output burst_order_e order_o,
  output logic         code_ok_o
);

  always_comb begin
    code_ok_o  = code_is_legal(mode_i[2:0]);
    len_log2_o = code_to_log2(mode_i[2:0]);
    order_o    = mode_i[3] ? ORD_ILV : ORD_SEQ;
  end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_col_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  len_log2_t        len_log2_i,
  output logic             active_o,
  output logic [OFS_W-1:0] beat_o,
  output logic             first_o,
  output logic             last_o
);

  logic             active_q;
  logic [OFS_W-1:0] beat_q;
  len_log2_t        len_q;
  logic             at_end_w;

  assign at_end_w = active_q && (beat_q == len_mask(len_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      len_q    <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      beat_q   <= '0;
      len_q    <= len_log2_i;
    end else if (active_q) begin
      if (at_end_w) active_q <= 1'b0;
      else          beat_q   <= beat_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign beat_o   = beat_q;
  assign first_o  = active_q && (beat_q == '0);
  assign last_o   = at_end_w;

  // R7: a load never lands on a running burst
  assert_no_load_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !active_q);

  // R7: the busy phase closes right after the final beat
  assert_end_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end_w && !load_i) |=> !active_q);

  // R2: the beat counter stays inside the programmed length
  assert_beat_in_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> ((beat_q & ~len_mask(len_q)) == '0));

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base_col_i,
  input  len_log2_t        len_log2_i,
  input  burst_order_e     order_i,
  input  logic [OFS_W-1:0] beat_i,
  output logic [COL_W-1:0] col_o
);

  logic [OFS_W-1:0] ofs_w;

  assign ofs_w = beat_offset(base_col_i[OFS_W-1:0], beat_i, order_i, len_log2_i);

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    if (i < OFS_W) begin : g_low
      assign col_o[i] = (i < int'(len_log2_i)) ? ofs_w[i] : base_col_i[i];
    end else begin : g_high
      assign col_o[i] = base_col_i[i];
    end
  end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [3:0]       mode_i,
  output logic [COL_W-1:0] col_o,
  output logic             col_vld_o,
  output logic             first_o,
  output logic             last_o,
  output logic             busy_o,
  output logic             err_o
);

  len_log2_t        dec_len_w;
  burst_order_e     dec_ord_w;
  logic             dec_ok_w;
  logic             accept_w;
  logic             reject_w;
  logic             active_w;
  logic [OFS_W-1:0] beat_w;

  logic [COL_W-1:0] base_q;
  len_log2_t        len_q;
  burst_order_e     ord_q;
  logic             err_q;

  burst_mode_dec u_dec (
    .mode_i     (mode_i),
    .len_log2_o (dec_len_w),
    .order_o    (dec_ord_w),
    .code_ok_o  (dec_ok_w)
  );

  assign accept_w = start_i && !active_w && dec_ok_w;
  assign reject_w = start_i && !active_w && !dec_ok_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
      ord_q  <= ORD_SEQ;
      err_q  <= 1'b0;
    end else begin
      err_q <= reject_w;
      if (accept_w) begin
        base_q <= start_col_i;
        len_q  <= dec_len_w;
        ord_q  <= dec_ord_w;
      end
    end
  end

  burst_beat_ctr u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (accept_w),
    .len_log2_i (dec_len_w),
    .active_o   (active_w),
    .beat_o     (beat_w),
    .first_o    (first_o),
    .last_o     (last_o)
  );

  burst_addr_map #(.COL_W(COL_W)) u_map (
    .base_col_i (base_q),
    .len_log2_i (len_q),
    .order_i    (ord_q),
    .beat_i     (beat_w),
    .col_o      (col_o)
  );

  assign col_vld_o = active_w;
  assign busy_o    = active_w;
  assign err_o     = err_q;

  // R5: bits above the largest block stay fixed between beats of one burst
  assert_upper_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (col_vld_o && !first_o) |-> (col_o[COL_W-1:OFS_W] == $past(col_o[COL_W-1:OFS_W])));

  // R6: first and last flags are distinct beats
  assert_first_last_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(first_o && last_o));

  // R2: a first beat always follows an accepted start
  assert_first_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    first_o |-> $past(accept_w));

  // R8: an error pulse never overlaps a burst
  assert_err_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !busy_o);

endmodule

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int COL_W      = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [3:0]       mode_i = '0;
  logic [COL_W-1:0] col_o;
  logic             col_vld_o, first_o, last_o, busy_o, err_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .mode_i(mode_i), .col_o(col_o), .col_vld_o(col_vld_o), .first_o(first_o),
    .last_o(last_o), .busy_o(busy_o), .err_o(err_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int beats_of(input logic [2:0] code);
    if (code == 3'd1) return 2;
    if (code == 3'd2) return 4;
    if (code == 3'd3) return 8;
    return 0;
  endfunction

  function automatic int model_col(input int s, input int len, input bit ilv, input int k);
    int off, o;
    off = s % len;
    o = ilv ? (off ^ k) : ((off + k) % len);
    return s - off + o;
  endfunction

  // drive start at a falling edge; returns at the falling edge showing beat 0
  task automatic pulse_start(input logic [COL_W-1:0] c, input logic [3:0] m);
    start_col_i = c;
    mode_i      = m;
    start_i     = 1'b1;
    @(negedge clk);
    start_i     = 1'b0;
  endtask

  // full burst with checks; intr_at >= 0 pulses a spurious start at that beat
  task automatic run_burst(input logic [COL_W-1:0] c, input logic [3:0] m, input int intr_at);
    int len;
    bit ilv;
    len = beats_of(m[2:0]);
    ilv = m[3];
    pulse_start(c, m);
    for (int k = 0; k < len; k++) begin
      int e;
      e = model_col(int'(c), len, ilv, k);
      check(col_o == COL_W'(e), ilv ? "R4 interleaved column" : "R3 sequential column", int'(col_o), e);
      check((col_o >> $clog2(len)) == (c >> $clog2(len)), "R5 block upper bits", int'(col_o), int'(c));
      check(col_vld_o && busy_o, "R2/R7 valid and busy during beat", int'(col_vld_o), 1);
      check(first_o == (k == 0), "R6 first flag", int'(first_o), int'(k == 0));
      check(last_o == (k == len - 1), "R6 last flag", int'(last_o), int'(k == len - 1));
      if (k == intr_at) begin
        start_col_i = ~c;
        mode_i      = {~m[3], 3'b011};
        start_i     = 1'b1;
      end
      @(negedge clk);
      start_i = 1'b0;
    end
    check(!col_vld_o && !busy_o && !first_o && !last_o, "R7 idle after last beat", int'(busy_o), 0);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!col_vld_o && !first_o && !last_o && !busy_o && !err_o, "R1 reset outputs", int'(busy_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!col_vld_o && !busy_o && !err_o, "R1 idle after reset", int'(col_vld_o), 0);

    // directed corner cases: wrap at block end, all lengths, both orders (R2, R3, R4, R5)
    run_burst(10'h0FF, 4'b0011, -1);
    run_burst(10'h0FF, 4'b1011, -1);
    run_burst(10'h2A6, 4'b0010, -1);
    run_burst(10'h2A6, 4'b1010, -1);
    run_burst(10'h3FF, 4'b0001, -1);
    run_burst(10'h001, 4'b1001, -1);

    // R7: start in mid burst ignored, start right after last beat accepted
    run_burst(10'h135, 4'b0011, 2);
    run_burst(10'h10A, 4'b1010, 3);
    run_burst(10'h3FD, 4'b0001, 0);

    // R8: reserved codes give an error pulse and no beats
    for (int r = 0; r < 8; r++) begin
      logic [2:0] code;
      code = 3'(r);
      if (beats_of(code) == 0) begin
        pulse_start(10'h155, {r[0], code});
        check(err_o == 1'b1, "R8 error pulse", int'(err_o), 1);
        check(!col_vld_o && !busy_o, "R8 no burst on reserved code", int'(col_vld_o), 0);
        @(negedge clk);
        check(err_o == 1'b0 && !col_vld_o, "R8 error lasts one cycle", int'(err_o), 0);
      end
    end

    // random bursts
    for (int i = 0; i < 300; i++) begin
      logic [COL_W-1:0] c;
      logic [3:0] m;
      c = COL_W'($urandom);
      m = {1'($urandom), 3'(($urandom % 3) + 1)};
      run_burst(c, m, ($urandom % 4 == 0) ? int'($urandom % 2) : -1);
      if ($urandom % 2 == 1) @(negedge clk);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule